// File: doc/BRIEF.md
# Hardware Lock Bank

This block is a bank of hardware semaphores shared by two processors on one chip. Each lock is one 32-bit word on a simple register port. A read of a lock word is the acquire attempt. It returns 1 when the lock was free and marks it taken in the same access. It returns 0 when the lock is already held, and then the lock is left unchanged. Writing the value zero to a lock word frees it. A status word at the bottom of the window shows every lock at once and changes nothing.

Two requester ports reach the same lock array. Each port has read-enable, write-enable, byte address and write data. Read data is registered and appears in the cycle after the access. When both ports touch the array in one cycle, all releases take effect first. Acquires are then granted in fixed port order, so port 0 wins a tie. Software that fails to get a lock simply polls again; repeated failed reads have no effect.

Top module: `hw_lock_bank`

## Requirements
- R1: After a synchronous reset every lock is free, so a status read returns 1 in each of bits 0 to 29 and 0 in bits 30 and 31.
- R2: A read of lock n at byte offset 0x404 + 4*n (n = 0..29, so the last lock is at 0x478) returns 1 when the lock is free, and lock n is taken from that access on.
- R3: A read of a taken lock returns 0 and leaves the lock taken, no matter how many such reads follow each other.
- R4: A write of the value 0 to a lock word frees that lock.
- R5: A write of any nonzero value to a lock word leaves the lock unchanged.
- R6: A read of the status word at byte offset 0x400 returns bit n = 1 when lock n is free, using the state from before that cycle's accesses, and changes no lock.
- R7: Writes to the status word or to an unmapped offset change no lock. Reads of an unmapped offset return 0. Unmapped covers offsets that are not word-aligned, offsets below 0x400 and offsets at or above 0x47C.
- R8: When both ports read the same free lock in one cycle, port 0 gets 1, port 1 gets 0, and the lock becomes taken.
- R9: A release write and an acquire read of the same lock in one cycle are served release-first. The read returns 1 and the lock ends up taken. This holds whether the two accesses come from one port or from both ports.
- R10: Read data is registered. It holds the result of the access made in the previous cycle, and it is 0 after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_rd_en | input | 1 | Port 0 read strobe (acquire attempt or status read) |
| p0_wr_en | input | 1 | Port 0 write strobe |
| p0_addr | input | 12 | Port 0 byte address |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rdata | output | 32 | Port 0 registered read data |
| p1_rd_en | input | 1 | Port 1 read strobe |
| p1_wr_en | input | 1 | Port 1 write strobe |
| p1_addr | input | 12 | Port 1 byte address |
| p1_wdata | input | 32 | Port 1 write data |
| p1_rdata | output | 32 | Port 1 registered read data |

## Verification
The hardest cases to reach are those where the two ports collide on one lock in one cycle. Examples are a tie between two acquire reads, and a release by one port while the other port reads the same lock. Random traffic on a full 30-lock map seldom produces these. The random phase therefore sends most addresses to a pool of four locks and mixes zero and nonzero write data. This makes ties, same-cycle release-and-acquire, and combined read-plus-write on one port common. Directed steps first set up each collision on purpose, including the last lock and the offsets just outside the map.

// File: rtl/hlb_pkg.sv
package hlb_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_STAT = 2'd1,
    TGT_LOCK = 2'd2
  } hlb_tgt_e;
endpackage

// File: rtl/hlb_decode.sv
module hlb_decode
  import hlb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_LOCKS = 30,
  parameter int STAT_OFS  = 'h400,
  parameter int BASE_OFS  = 'h404,
  parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output hlb_tgt_e          tgt,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_zero
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-3:0] SLOTS  = (ADDR_W-2)'(NUM_LOCKS);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-3:0] slot;

  always_comb begin
    rel     = addr - BASE_A;
    slot    = rel[ADDR_W-1:2];
    idx     = slot[IDX_W-1:0];
    wr_zero = (wdata == '0);
    if (addr == STAT_A)
      tgt = TGT_STAT;
    else if ((addr >= BASE_A) && (rel[1:0] == 2'b00) && (slot < SLOTS))
      tgt = TGT_LOCK;
    else
      tgt = TGT_NONE;
  end
endmodule

// File: rtl/hlb_state.sv
module hlb_state #(
  parameter int NUM_LOCKS = 30,
  parameter int NUM_PORTS = 2,
  parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PORTS-1:0]             acq_req,
  input  logic [NUM_PORTS-1:0]             rel_req,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]  req_idx,
  output logic [NUM_PORTS-1:0]             grant,
  output logic [NUM_LOCKS-1:0]             free_q
);
  logic [NUM_LOCKS-1:0] rel_mask;
  logic [NUM_LOCKS-1:0] avail;
  logic [NUM_LOCKS-1:0] take;
  logic [NUM_LOCKS-1:0] free_d;

  // Releases land first, then acquires are granted in ascending port order.
  always_comb begin
    rel_mask = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rel_req[p]) rel_mask[req_idx[p]] = 1'b1;
    avail = free_q | rel_mask;
    take  = '0;
    grant = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (acq_req[p] && avail[req_idx[p]] && !take[req_idx[p]]) begin
        grant[p]          = 1'b1;
        take[req_idx[p]]  = 1'b1;
      end
    end
    free_d = avail & ~take;
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= '1;
    else     free_q <= free_d;
  end

  AST_RESET_FREE: assert property (@(posedge clk) ($past(rst) && !rst) |-> (&free_q)); // R1

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_TAKE_STICKS: assert property (@(posedge clk) disable iff (rst)
      grant[p] |=> !free_q[$past(req_idx[p])]); // R2
    AST_DENY_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (acq_req[p] && !free_q[req_idx[p]] && !rel_mask[req_idx[p]])
        |=> !free_q[$past(req_idx[p])]); // R3
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (rst)
      (rel_req[p] && !take[req_idx[p]]) |=> free_q[$past(req_idx[p])]); // R4
  end

  if (NUM_PORTS > 1) begin : g_pair
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
      (grant[0] && grant[1]) |-> (req_idx[0] != req_idx[1])); // R8
  end
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
  import hlb_pkg::*;
#(
  parameter int NUM_LOCKS = 30,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int STAT_OFS  = 'h400,
  parameter int BASE_OFS  = 'h404
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p0_rd_en,
  input  logic              p0_wr_en,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_rd_en,
  input  logic              p1_wr_en,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic [DATA_W-1:0] p1_rdata
);
  localparam int NUM_PORTS = 2;
  localparam int IDX_W     = $clog2(NUM_LOCKS);

  logic [NUM_PORTS-1:0]              rd_en;
  logic [NUM_PORTS-1:0]              wr_en;
  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata;
  hlb_tgt_e                          tgt   [NUM_PORTS];
  logic [NUM_PORTS-1:0][IDX_W-1:0]   idx;
  logic [NUM_PORTS-1:0]              wr_zero;
  logic [NUM_PORTS-1:0]              acq_req;
  logic [NUM_PORTS-1:0]              rel_req;
  logic [NUM_PORTS-1:0]              grant;
  logic [NUM_LOCKS-1:0]              free_q;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  rd_d;
  logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_q;

  assign rd_en = {p1_rd_en, p0_rd_en};
  assign wr_en = {p1_wr_en, p0_wr_en};
  assign addr  = {p1_addr, p0_addr};
  assign wdata = {p1_wdata, p0_wdata};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    hlb_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS),
      .STAT_OFS(STAT_OFS), .BASE_OFS(BASE_OFS), .IDX_W(IDX_W)
    ) u_dec (
      .addr(addr[p]), .wdata(wdata[p]),
      .tgt(tgt[p]), .idx(idx[p]), .wr_zero(wr_zero[p])
    );

    assign acq_req[p] = rd_en[p] && (tgt[p] == TGT_LOCK);
    assign rel_req[p] = wr_en[p] && (tgt[p] == TGT_LOCK) && wr_zero[p];

    always_comb begin
      rd_d[p] = '0;
      if (rd_en[p]) begin
        if (tgt[p] == TGT_LOCK)      rd_d[p][0] = grant[p];
        else if (tgt[p] == TGT_STAT) rd_d[p][NUM_LOCKS-1:0] = free_q;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) rdata_q[p] <= '0;
      else     rdata_q[p] <= rd_d[p];
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd_en[p] && (tgt[p] == TGT_NONE)) |=> (rdata_q[p] == '0)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !rd_en[p] |=> (rdata_q[p] == '0)); // R10
  end

  hlb_state #(
    .NUM_LOCKS(NUM_LOCKS), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)
  ) u_state (
    .clk(clk), .rst(rst),
    .acq_req(acq_req), .rel_req(rel_req), .req_idx(idx),
    .grant(grant), .free_q(free_q)
  );

  assign p0_rdata = rdata_q[0];
  assign p1_rdata = rdata_q[1];
endmodule

// File: tb/tb_hw_lock_bank.sv
`timescale 1ns/1ps
module tb_hw_lock_bank;
  localparam int NL = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        p0_rd_en = 0, p0_wr_en = 0, p1_rd_en = 0, p1_wr_en = 0;
  logic [11:0] p0_addr = '0, p1_addr = '0;
  logic [31:0] p0_wdata = '0, p1_wdata = '0;
  logic [31:0] p0_rdata, p1_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [NL-1:0] mfree;

  always #2.5 clk = ~clk;

  hw_lock_bank dut (
    .clk(clk), .rst(rst),
    .p0_rd_en(p0_rd_en), .p0_wr_en(p0_wr_en), .p0_addr(p0_addr),
    .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_rd_en(p1_rd_en), .p1_wr_en(p1_wr_en), .p1_addr(p1_addr),
    .p1_wdata(p1_wdata), .p1_rdata(p1_rdata)
  );

  function automatic int slot_of(logic [11:0] a);
    if (a >= 12'h404 && a[1:0] == 2'b00 && ((int'(a) - 'h404) / 4) < NL)
      return (int'(a) - 'h404) / 4;
    return -1;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle on both ports; expected data comes from the bench model.
  task automatic step(string tag,
                      bit r0, bit w0, logic [11:0] a0, logic [31:0] d0,
                      bit r1, bit w1, logic [11:0] a1, logic [31:0] d1);
    logic [31:0] e0, e1;
    logic [NL-1:0] avail, take;
    int s0, s1;
    @(negedge clk);
    p0_rd_en = r0; p0_wr_en = w0; p0_addr = a0; p0_wdata = d0;
    p1_rd_en = r1; p1_wr_en = w1; p1_addr = a1; p1_wdata = d1;
    s0 = slot_of(a0); s1 = slot_of(a1);
    avail = mfree;
    if (w0 && s0 >= 0 && d0 == 0) avail[s0] = 1'b1;
    if (w1 && s1 >= 0 && d1 == 0) avail[s1] = 1'b1;
    take = '0; e0 = '0; e1 = '0;
    if (r0) begin
      if (s0 >= 0) begin
        if (avail[s0]) begin e0 = 1; take[s0] = 1'b1; end
      end else if (a0 == 12'h400) e0 = {2'b00, mfree};
    end
    if (r1) begin
      if (s1 >= 0) begin
        if (avail[s1] && !take[s1]) begin e1 = 1; take[s1] = 1'b1; end
      end else if (a1 == 12'h400) e1 = {2'b00, mfree};
    end
    mfree = avail & ~take;
    @(posedge clk);
    #1;
    check({tag, " p0"}, p0_rdata, e0);
    check({tag, " p1"}, p1_rdata, e1);
    p0_rd_en = 0; p0_wr_en = 0; p1_rd_en = 0; p1_wr_en = 0;
  endtask

  function automatic logic [11:0] lk(int n);
    return 12'(32'h404 + 4 * n);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    mfree = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 idle, R1 reset state
    step("R10 idle", 0,0,12'h0,0, 0,0,12'h0,0);
    step("R1 reset", 1,0,12'h400,0, 0,0,12'h0,0);
    check("R1 status value", p0_rdata, 32'h3FFF_FFFF);
    // R2 acquire, R3 repeated polling
    step("R2 acquire", 1,0,lk(5),0, 0,0,12'h0,0);
    step("R3 poll", 1,0,lk(5),0, 0,0,12'h0,0);
    step("R3 poll again", 0,0,12'h0,0, 1,0,lk(5),0);
    // R6 status shows taken bit and has no side effect
    step("R6 status", 1,0,12'h400,0, 1,0,12'h400,0);
    check("R6 bit5 clear", p0_rdata, 32'h3FFF_FFDF);
    step("R6 status repeat", 1,0,12'h400,0, 0,0,12'h0,0);
    // R5 nonzero write ignored
    step("R5 write nonzero", 0,0,12'h0,0, 0,1,lk(5),32'h7);
    step("R5 still taken", 1,0,lk(5),0, 0,0,12'h0,0);
    // R4 release
    step("R4 release", 0,0,12'h0,0, 0,1,lk(5),0);
    step("R4 reacquire", 1,0,lk(5),0, 0,0,12'h0,0);
    check("R4 got lock", p0_rdata, 32'h1);
    // R8 tie
    step("R8 tie", 1,0,lk(9),0, 1,0,lk(9),0);
    check("R8 port0 wins", p0_rdata, 32'h1);
    check("R8 port1 loses", p1_rdata, 32'h0);
    // R9 release and acquire together, across ports then on one port
    step("R9 cross", 0,1,lk(9),0, 1,0,lk(9),0);
    check("R9 cross read", p1_rdata, 32'h1);
    step("R9 same port", 1,1,lk(9),0, 0,0,12'h0,0);
    check("R9 same read", p0_rdata, 32'h1);
    // R2 last lock, R7 edges
    step("R2 last lock", 1,0,lk(29),0, 1,0,12'h47C,0);
    check("R2 last", p0_rdata, 32'h1);
    check("R7 past end", p1_rdata, 32'h0);
    step("R7 misaligned", 1,0,12'h406,0, 1,0,12'h3FC,0);
    step("R7 write status", 0,1,12'h400,0, 0,1,12'h47C,0);
    step("R7 write misaligned", 0,1,12'h416,0, 0,0,12'h0,0);
    step("R7 state kept", 1,0,12'h400,0, 0,0,12'h0,0);
    step("R10 after read", 0,0,12'h0,0, 0,0,12'h0,0);
    // Random mix focused on a small lock pool
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a [2];
      logic [31:0] d [2];
      bit r [2];
      bit w [2];
      for (int p = 0; p < 2; p++) begin
        int k = $urandom_range(0, 9);
        if (k < 6)      a[p] = lk($urandom_range(0, 3));
        else if (k < 7) a[p] = lk($urandom_range(0, NL-1));
        else if (k < 8) a[p] = 12'h400;
        else            a[p] = 12'($urandom_range(0, 4095));
        d[p] = ($urandom_range(0, 3) == 0) ? $urandom : 32'h0;
        r[p] = $urandom_range(0, 1);
        w[p] = ($urandom_range(0, 2) == 0);
      end
      step("RND", r[0],w[0],a[0],d[0], r[1],w[1],a[1],d[1]);
    end
    step("R6 final status", 1,0,12'h400,0, 0,0,12'h0,0);
    finish_run();
  end
endmodule